// File: doc/BRIEF.md
# In-System Programming Serial Command Slave

This block is the target side of a four-byte serial programming link. It oversamples a serial clock, a serial data input and a programming reset line with the system clock. It assembles the incoming bits into bytes and the bytes into four-byte instructions. It also drives the serial data output. The link only opens after an enable handshake. In that handshake the target shifts its second received byte back while the third byte arrives, so the host can tell whether both ends agree on bit alignment.

Once the link is open, the block decodes three memory commands: page-buffer load, page write and byte read. Each one becomes a single-cycle request carrying an operation code, a 16-bit address and a data byte. For a read, the data that the memory side returns is captured and shifted out during the last byte of the same instruction. The only way to recover from lost alignment is a pulse on the programming reset line. That pulse clears the framing counters and closes the link.

Top module: `isp_slave`

## Requirements
- R1: The data input is sampled on each rising serial clock edge, most significant bit first. Every instruction is exactly four bytes long, and the byte counter returns to the first byte after the fourth whatever the contents were.
- R2: The data output changes only after a falling serial clock edge (or when cleared by a reset). It holds its value from just before a rising edge until the following falling edge.
- R3: An instruction whose first byte is 0xAC sends its second byte back on the data output during the third byte. The link opens at the end of that instruction only if the second byte was 0x53.
- R4: While the link is closed, every instruction other than the enable handshake produces no request, and the data output stays 0.
- R5: While the programming reset input is high, and while the synchronous reset is high, the bit and byte counters are held at zero, the link is closed, the data output is 0 and no request is issued. A handshake sent after the pulse opens the link again.
- R6: With the link open, first byte 0x40 issues one request at the end of the fourth byte: operation 0 (load), address = {byte 2, byte 3}, data = byte 4.
- R7: With the link open, first byte 0x4C issues one request at the end of the fourth byte: operation 1 (write), address = {byte 2, byte 3}, data = byte 4.
- R8: With the link open, first byte 0x20 issues a request at the end of the third byte: operation 2 (read), address = {byte 2, byte 3}, data 0. The read-data input is captured at the start of the fourth byte and shifted out during it, most significant bit first.
- R9: With the link open, any other first byte produces no request and a data output of 0, and the next instruction is still framed correctly.
- R10: A request is asserted for exactly one system clock. Its address, operation and data hold until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_pin | input | 1 | Serial clock from the host, asynchronous |
| mosi_pin | input | 1 | Serial data from the host, asynchronous |
| prog_rst_pin | input | 1 | Programming reset, active high, asynchronous |
| rd_data | input | 8 | Memory read data for the current request address |
| miso | output | 1 | Serial data to the host |
| req_valid | output | 1 | Single-cycle memory request strobe |
| req_op | output | 2 | Request operation: 0 load, 1 write, 2 read |
| req_addr | output | 16 | Request address |
| req_wdata | output | 8 | Request data byte (0 for reads) |

## Verification
A counter that drifts by one bit shows up within a single instruction. The echoed handshake byte comes back rotated, and every later request carries shifted address and data fields. A bad byte count shows up as a missing or early request at the end of the next instruction. A link-state flag that stays set after a reset pulse produces a request from an instruction that should have been ignored, on the first command after the pulse. An output register that updates on the wrong edge is caught on the very next bit, because the host-side model compares the output before each rising edge with its value later in the high phase.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } isp_op_e;

  localparam logic [7:0] CMD_ENABLE = 8'hAC;
  localparam logic [7:0] SYNC_BYTE  = 8'h53;
  localparam logic [7:0] CMD_LOAD   = 8'h40;
  localparam logic [7:0] CMD_WRITE  = 8'h4C;
  localparam logic [7:0] CMD_READ   = 8'h20;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/isp_framer.sv
module isp_framer #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4,
  localparam int BIT_CW  = $clog2(BYTE_W),
  localparam int BYTE_CW = $clog2(NBYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               sck_s,
  input  logic               mosi_s,
  output logic               rise,
  output logic               fall,
  output logic [BIT_CW-1:0]  bit_cnt,
  output logic [BYTE_CW-1:0] byte_cnt,
  output logic               byte_done,
  output logic [BYTE_CW-1:0] done_idx,
  output logic [BYTE_W-1:0]  rx_byte
);
  localparam logic [BIT_CW-1:0]  LAST_BIT  = BIT_CW'(BYTE_W - 1);
  localparam logic [BYTE_CW-1:0] LAST_BYTE = BYTE_CW'(NBYTES - 1);

  logic              sck_q;
  logic [BYTE_W-2:0] sr_q;
  logic [BYTE_W-1:0] rx_next;

  assign rise    = sck_s & ~sck_q & ~clr;
  assign fall    = ~sck_s & sck_q & ~clr;
  assign rx_next = {sr_q, mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      sr_q      <= '0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      byte_done <= 1'b0;
      done_idx  <= '0;
      rx_byte   <= '0;
    end else if (clr) begin
      sck_q     <= sck_s;
      sr_q      <= '0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      byte_done <= 1'b0;
    end else begin
      sck_q     <= sck_s;
      byte_done <= 1'b0;
      if (rise) begin
        sr_q <= rx_next[BYTE_W-2:0];
        if (bit_cnt == LAST_BIT) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          done_idx  <= byte_cnt;
          rx_byte   <= rx_next;
          byte_cnt  <= (byte_cnt == LAST_BYTE) ? '0 : byte_cnt + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R1
  done_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> $past(rise));

  // R5
  clr_zeroes_counters_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bit_cnt == '0 && byte_cnt == '0 && !byte_done));
endmodule

// File: rtl/isp_txshift.sv
module isp_txshift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              fall,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  output logic              miso
);
  logic [BYTE_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr_q <= '0;
    end else if (fall) begin
      if (load) sr_q <= load_val;
      else      sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso = sr_q[BYTE_W-1];

  // R2
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> ($past(fall) || $past(clr)));
endmodule

// File: rtl/isp_slave.sv
module isp_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  localparam int NBYTES  = 4,
  localparam int ADDR_W  = 2 * BYTE_W,
  localparam int BIT_CW  = $clog2(BYTE_W),
  localparam int BYTE_CW = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_pin,
  input  logic              mosi_pin,
  input  logic              prog_rst_pin,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              miso,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BYTE_W-1:0] req_wdata
);
  import isp_pkg::*;

  logic               sck_s, mosi_s, prst_s;
  logic               rise, fall, byte_done;
  logic [BIT_CW-1:0]  bit_cnt;
  logic [BYTE_CW-1:0] byte_cnt, done_idx;
  logic [BYTE_W-1:0]  rx_byte, tx_val;
  logic [BYTE_W-1:0]  b0_q, b1_q, b2_q;
  logic               enabled_q, rd_pend_q;

  isp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({prog_rst_pin, sck_pin, mosi_pin}),
    .q   ({prst_s, sck_s, mosi_s})
  );

  isp_framer #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .clr       (prst_s),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .rise      (rise),
    .fall      (fall),
    .bit_cnt   (bit_cnt),
    .byte_cnt  (byte_cnt),
    .byte_done (byte_done),
    .done_idx  (done_idx),
    .rx_byte   (rx_byte)
  );

  always_comb begin
    tx_val = '0;
    if (byte_cnt == BYTE_CW'(2) && b0_q == CMD_ENABLE)
      tx_val = b1_q;
    else if (byte_cnt == BYTE_CW'(3) && rd_pend_q)
      tx_val = rd_data;
  end

  isp_txshift #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .clr      (prst_s),
    .fall     (fall),
    .load     (bit_cnt == '0),
    .load_val (tx_val),
    .miso     (miso)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_op    <= OP_LOAD;
      req_addr  <= '0;
      req_wdata <= '0;
    end
    if (rst || prst_s) begin
      enabled_q <= 1'b0;
      rd_pend_q <= 1'b0;
      req_valid <= 1'b0;
      b0_q      <= '0;
      b1_q      <= '0;
      b2_q      <= '0;
    end else begin
      req_valid <= 1'b0;
      if (byte_done) begin
        case (done_idx)
          BYTE_CW'(0): b0_q <= rx_byte;
          BYTE_CW'(1): b1_q <= rx_byte;
          BYTE_CW'(2): begin
            b2_q <= rx_byte;
            if (enabled_q && b0_q == CMD_READ) begin
              req_valid <= 1'b1;
              req_op    <= OP_READ;
              req_addr  <= {b1_q, rx_byte};
              req_wdata <= '0;
              rd_pend_q <= 1'b1;
            end
          end
          default: begin
            rd_pend_q <= 1'b0;
            if (b0_q == CMD_ENABLE) begin
              enabled_q <= enabled_q | (b1_q == SYNC_BYTE);
            end else if (enabled_q && (b0_q == CMD_LOAD || b0_q == CMD_WRITE)) begin
              req_valid <= 1'b1;
              req_op    <= (b0_q == CMD_LOAD) ? OP_LOAD : OP_WRITE;
              req_addr  <= {b1_q, b2_q};
              req_wdata <= rx_byte;
            end
          end
        endcase
      end
    end
  end

  // R10
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R4
  req_needs_link_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(enabled_q));

  // R5
  no_req_in_prst_chk: assert property (@(posedge clk) disable iff (rst)
    prst_s |=> (!req_valid && !enabled_q));

  // R10
  req_fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> ($stable(req_addr) && $stable(req_op) && $stable(req_wdata)));
endmodule

// File: tb/isp_slave_test.sv
module isp_slave_test;
  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst, sck, mosi, prst;
  logic [7:0]  rd_data;
  logic        miso, req_valid;
  logic [1:0]  req_op;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;

  int errors = 0;
  int checks = 0;
  logic [25:0] expq[$];
  bit en_m = 1'b0;
  bit prev_v = 1'b0;

  always #5 clk = ~clk;

  isp_slave uut (
    .clk          (clk),
    .rst          (rst),
    .sck_pin      (sck),
    .mosi_pin     (mosi),
    .prog_rst_pin (prst),
    .rd_data      (rd_data),
    .miso         (miso),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata)
  );

  function automatic logic [7:0] rdfn(logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'h3C;
  endfunction

  assign rd_data = rdfn(req_addr);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (req_valid) begin
        chk(!prev_v, "R10", "strobe wider than one cycle", 1, 0);
        if (expq.size() == 0) begin
          chk(1'b0, "R4 R9", "unexpected request", {req_op, req_addr, req_wdata}, 0);
        end else begin
          logic [25:0] e;
          e = expq.pop_front();
          chk({req_op, req_addr, req_wdata} == e,
              (e[25:24] == 2'd0) ? "R6" : (e[25:24] == 2'd1) ? "R7" : "R8",
              "request fields", {req_op, req_addr, req_wdata}, e);
        end
      end
      prev_v = req_valid;
    end
  end

  task automatic xbit(input logic b, output logic r);
    logic m1;
    mosi = b;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    r  = miso;
    m1 = miso;
    sck = 1'b1;
    repeat (HALF - 1) @(posedge clk);
    @(negedge clk);
    chk(miso == m1, "R2", "output moved while clock high", miso, m1);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      xbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cmd(input logic [7:0] b0, b1, b2, b3);
    logic [7:0] rx0, rx1, rx2, rx3, e2, e3;
    string l2, l3;
    e2 = (b0 == 8'hAC) ? b1 : 8'h00;
    l2 = (b0 == 8'hAC) ? "R3" : "R1";
    e3 = 8'h00;
    l3 = !en_m ? "R4" : (b0 == 8'h20) ? "R8" : "R9";
    if (en_m) begin
      if (b0 == 8'h20) begin
        expq.push_back({2'd2, b1, b2, 8'h00});
        e3 = rdfn({b1, b2});
      end else if (b0 == 8'h40) begin
        expq.push_back({2'd0, b1, b2, b3});
      end else if (b0 == 8'h4C) begin
        expq.push_back({2'd1, b1, b2, b3});
      end
    end
    xbyte(b0, rx0);
    xbyte(b1, rx1);
    xbyte(b2, rx2);
    xbyte(b3, rx3);
    chk(rx0 == 8'h00, "R1", "byte 1 output", rx0, 0);
    chk(rx1 == 8'h00, "R1", "byte 2 output", rx1, 0);
    chk(rx2 == e2, l2, "byte 3 output", rx2, e2);
    chk(rx3 == e3, l3, "byte 4 output", rx3, e3);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0, l3, "requests still missing", expq.size(), 0);
    expq.delete();
    if (b0 == 8'hAC && b1 == 8'h53) en_m = 1'b1;
  endtask

  task automatic pulse_prst();
    prst = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(miso == 1'b0, "R5", "output during programming reset", miso, 0);
    chk(req_valid == 1'b0, "R5", "strobe during programming reset", req_valid, 0);
    prst = 1'b0;
    repeat (6) @(posedge clk);
    en_m = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; sck = 1'b0; mosi = 1'b0; prst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(miso == 1'b0, "R5", "output in reset", miso, 0);
    chk(req_valid == 1'b0, "R5", "strobe in reset", req_valid, 0);
    rst = 1'b0;
    repeat (4) @(posedge clk);

    // R4: commands before the handshake
    cmd(8'h20, 8'h00, 8'h10, 8'h00);
    // R3: failed handshake echoes the wrong byte, link stays closed
    cmd(8'hAC, 8'h52, 8'h00, 8'h00);
    cmd(8'h40, 8'h00, 8'h05, 8'hA7);

    // R5: partial instruction then recovery pulse
    for (int i = 0; i < 5; i++) begin
      logic r;
      xbit(1'b1, r);
    end
    pulse_prst();

    // R3: good handshake
    cmd(8'hAC, 8'h53, 8'h00, 8'h00);
    // R6 loads, including edge bit patterns
    cmd(8'h40, 8'h00, 8'h05, 8'hA7);
    cmd(8'h40, 8'h80, 8'h01, 8'h81);
    // R7 write
    cmd(8'h4C, 8'h01, 8'h20, 8'h00);
    // R8 reads
    cmd(8'h20, 8'h12, 8'h34, 8'h00);
    cmd(8'h20, 8'hFF, 8'hFF, 8'h55);
    // R9 unknown opcode, then framing still correct
    cmd(8'h7E, 8'h11, 8'h22, 8'h33);
    cmd(8'h40, 8'h3C, 8'hC3, 8'h01);
    // R5: pulse closes the link
    pulse_prst();
    cmd(8'h4C, 8'h00, 8'h00, 8'hFF);
    cmd(8'hAC, 8'h53, 8'h00, 8'h00);
    cmd(8'h20, 8'h00, 8'h00, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule